// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a shared word memory used by several requesters and gives them the pair of primitives needed to build locks without bus lock lines. Each cycle a round-robin arbiter picks at most one pending request. The granted operation is a plain load, a plain store, a load-linked or a store-conditional. A load-linked returns the word unchanged and arms a reservation for the requester on the coherence block that holds the word. A later store-conditional from that requester commits only if the reservation is still armed and names the same block.

Any committed write clears every other requester's reservation on the written block. A committed write is either a plain store or a store-conditional that succeeds. A failed store-conditional leaves memory and all reservations exactly as they were, so it is invisible to the other requesters. Software releases a lock by storing zero with an ordinary store. The reply comes one cycle after the grant as a pulse on the grantee's response bit, together with a success flag and the word that memory held before the operation.

Top module: `llsc_monitor`

## Requirements
- R1: While reset is held, no grant and no response is given. After reset no reservation is armed, so a store-conditional from any requester fails.
- R2: At most one request is granted per cycle, and only to a requester whose valid is high. After requester g is granted, the next grant goes to the first contending requester in the order g+1, g+2, … modulo the requester count. Requester 0 has first priority after reset.
- R3: A request granted in cycle t raises only that requester's bit of `rsp_valid` in cycle t+1. In that cycle `rsp_rdata` holds the addressed word as it was before the operation.
- R4: A load-linked (op code 2) returns the stored word unchanged with `rsp_ok`=1 and arms the requester's reservation on block `addr >> BLK_OFF_W`.
- R5: A store-conditional (op code 3) succeeds when the requester's reservation is armed and its block equals the target block. It then writes the word and answers `rsp_ok`=1.
- R6: A store-conditional that does not succeed writes nothing, answers `rsp_ok`=0 and leaves every requester's reservation unchanged.
- R7: A plain store (op code 1) or a successful store-conditional disarms every other requester's reservation on the same block. Reservations on other blocks stay armed. The store itself answers `rsp_ok`=1.
- R8: Matching is by block only. A store-conditional to any word of the reserved block can succeed, and a foreign write to any word of that block cancels the reservation.
- R9: A new load-linked replaces the requester's previous reservation.
- R10: A successful store-conditional disarms the issuing requester's own reservation, so a second store-conditional without a new load-linked fails.
- R11: A plain load (op code 0) returns the word with `rsp_ok`=1 and changes no reservation. A plain store leaves the storing requester's own reservation armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_REQ | Request pending, one bit per requester, held until granted |
| req_op | input | 2*NUM_REQ | Operation per requester: 0 load, 1 store, 2 load-linked, 3 store-conditional |
| req_addr | input | ADDR_W*NUM_REQ | Word address per requester |
| req_wdata | input | DATA_W*NUM_REQ | Write data per requester |
| req_grant | output | NUM_REQ | One-hot grant in the current cycle |
| rsp_valid | output | NUM_REQ | One-cycle response pulse to the requester granted in the previous cycle |
| rsp_ok | output | 1 | Success flag of the response |
| rsp_rdata | output | DATA_W | Memory word before the operation |

## Verification
The bench builds the block with four requesters, 32 words and four words per block. That gives eight blocks, so every word can be preloaded and followed by a model in the bench. With this size the bench can walk every ordered pair of requesters, every one of the four operations as the interfering access, and every word offset inside the reserved block plus a word in a neighbouring block. Each of these combinations runs between a load-linked and its store-conditional. Four requesters are also enough to check round-robin rotation with all of them contending and with sparse subsets that force the pointer to skip idle requesters.

// File: rtl/llsc_pkg.sv
// Package: shared operation encoding for the reservation monitor.
// Assumes a 2-bit operation code on every requester port.
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LL    = 2'd2,
        OP_SC    = 2'd3
    } llsc_op_e;

endpackage

// File: rtl/llsc_rr_arb.sv
// Round-robin single-grant arbiter.
// Searches from the requester after the last grantee; at most one grant
// per cycle. Assumes requests are held until granted. After reset the
// last-grantee pointer sits at N-1 so requester 0 wins first.
module llsc_rr_arb #(
    parameter int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             grant_any
);

    logic [IDX_W-1:0] last_q;

    // Pick the first requester after the last grantee, wrapping around.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = (int'(last_q) + k) % N;
            if (!grant_any && req[cand]) begin
                grant_any       = 1'b1;
                grant[cand]     = 1'b1;
                grant_idx       = IDX_W'(cand);
            end
        end
    end

    // Remember the most recent grantee for the next search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IDX_W'(N - 1);
        end else if (grant_any) begin
            last_q <= grant_idx;
        end
    end

endmodule

// File: rtl/llsc_resv_table.sv
// Reservation table: one armed bit and block tag per requester.
// The granted requester's entry is armed by load-linked and disarmed by its
// own successful store-conditional. Every other entry on the written block
// is disarmed when a write commits. Assumes the caller raises wr_commit
// only for a plain store or a passing store-conditional.
module llsc_resv_table
    import llsc_pkg::*;
#(
    parameter int N     = 4,
    parameter int TAG_W = 6,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  llsc_op_e         upd_op,
    input  logic [TAG_W-1:0] upd_blk,
    input  logic             wr_commit,
    output logic             sc_pass,
    output logic [N-1:0]     resv_valid
);

    logic [TAG_W-1:0] tag_q [N];

    // Lookup for the granted requester's own reservation.
    always_comb begin
        sc_pass = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (upd_idx == IDX_W'(i)) begin
                sc_pass = resv_valid[i] && (tag_q[i] == upd_blk);
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_entry
        logic own;
        logic hit;

        // Decode whether this entry is the grantee or a victim on the block.
        always_comb begin
            own = (upd_idx == IDX_W'(i));
            hit = resv_valid[i] && (tag_q[i] == upd_blk);
        end

        // Update one requester's reservation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                resv_valid[i] <= 1'b0;
                tag_q[i]      <= '0;
            end else if (upd_en) begin
                if (own) begin
                    if (upd_op == OP_LL) begin
                        resv_valid[i] <= 1'b1;
                        tag_q[i]      <= upd_blk;
                    end else if (upd_op == OP_SC && wr_commit) begin
                        resv_valid[i] <= 1'b0;
                    end
                end else if (wr_commit && hit) begin
                    resv_valid[i] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/llsc_word_mem.sv
// Single-port word memory with read-before-write.
// rdata returns the word held before any write in the same access.
// The array is not reset; its content is undefined until written.
module llsc_word_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Read the old word and, when told to, store the new one.
    always_ff @(posedge clk) begin
        if (en) begin
            rdata <= mem_q[addr];
            if (we) begin
                mem_q[addr] <= wdata;
            end
        end
    end

endmodule

// File: rtl/llsc_monitor.sv
// Load-linked / store-conditional reservation monitor.
// NUM_REQ requesters share one memory. A round-robin arbiter admits one
// operation per cycle; the reservation table decides store-conditional
// success and kills foreign reservations on committed writes. The response
// is a one-cycle pulse on the grantee's bit in the next cycle.
// Assumes each requester holds its request fields stable until granted.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_REQ   = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int BLK_OFF_W = 2,
    localparam int IDX_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
    localparam int TAG_W    = ADDR_W - BLK_OFF_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_REQ-1:0]          req_valid,
    input  logic [2*NUM_REQ-1:0]        req_op,
    input  logic [ADDR_W*NUM_REQ-1:0]   req_addr,
    input  logic [DATA_W*NUM_REQ-1:0]   req_wdata,
    output logic [NUM_REQ-1:0]          req_grant,
    output logic [NUM_REQ-1:0]          rsp_valid,
    output logic                        rsp_ok,
    output logic [DATA_W-1:0]           rsp_rdata
);

    logic [NUM_REQ-1:0] req_live;
    logic [IDX_W-1:0]   gnt_idx;
    logic               gnt_any;
    llsc_op_e           gnt_op;
    logic [ADDR_W-1:0]  gnt_addr;
    logic [DATA_W-1:0]  gnt_wdata;
    logic [TAG_W-1:0]   gnt_blk;
    logic               sc_pass;
    logic               mem_we;
    logic [NUM_REQ-1:0] resv_valid;

    // Hold off all requests while reset is asserted.
    always_comb begin
        req_live = rst_n ? req_valid : '0;
    end

    llsc_rr_arb #(
        .N (NUM_REQ)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_live),
        .grant     (req_grant),
        .grant_idx (gnt_idx),
        .grant_any (gnt_any)
    );

    // Select the granted requester's operation, address and data.
    always_comb begin
        gnt_op    = OP_LOAD;
        gnt_addr  = '0;
        gnt_wdata = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (gnt_idx == IDX_W'(i)) begin
                gnt_op    = llsc_op_e'(req_op[2*i +: 2]);
                gnt_addr  = req_addr[ADDR_W*i +: ADDR_W];
                gnt_wdata = req_wdata[DATA_W*i +: DATA_W];
            end
        end
        gnt_blk = gnt_addr[ADDR_W-1:BLK_OFF_W];
    end

    // A write commits for a plain store or a passing store-conditional.
    always_comb begin
        mem_we = gnt_any &&
                 ((gnt_op == OP_STORE) || (gnt_op == OP_SC && sc_pass));
    end

    llsc_resv_table #(
        .N     (NUM_REQ),
        .TAG_W (TAG_W)
    ) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (gnt_any),
        .upd_idx    (gnt_idx),
        .upd_op     (gnt_op),
        .upd_blk    (gnt_blk),
        .wr_commit  (mem_we),
        .sc_pass    (sc_pass),
        .resv_valid (resv_valid)
    );

    llsc_word_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk   (clk),
        .en    (gnt_any),
        .we    (mem_we),
        .addr  (gnt_addr),
        .wdata (gnt_wdata),
        .rdata (rsp_rdata)
    );

    // Register the response pulse and its success flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_ok    <= 1'b0;
        end else begin
            rsp_valid <= req_grant;
            rsp_ok    <= gnt_any && ((gnt_op != OP_SC) || sc_pass);
        end
    end

endmodule

// File: rtl/llsc_monitor_chk.sv
// Checker for llsc_monitor: arbitration, response timing and reservation
// side effects. Attached to every instance of the top through bind.
module llsc_monitor_chk
    import llsc_pkg::*;
#(
    parameter int NUM_REQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_valid,
    input  logic [NUM_REQ-1:0] req_grant,
    input  logic [NUM_REQ-1:0] rsp_valid,
    input  logic               rsp_ok,
    input  logic               gnt_any,
    input  llsc_op_e           gnt_op,
    input  logic               sc_pass,
    input  logic [NUM_REQ-1:0] resv_valid
);

    // R2: never more than one grant.
    p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_grant));

    // R2: grants only go to requesters that ask.
    p_grant_asked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant & ~req_valid) == '0);

    // R3: response pulse mirrors the previous cycle's grant.
    p_rsp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rsp_valid == $past(req_grant));

    // R4: load-linked arms the grantee's reservation.
    p_ll_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && gnt_op == OP_LL) |=> (resv_valid & $past(req_grant)) != '0);

    // R5: a failing response can only come from a store-conditional.
    p_fail_is_sc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid != '0 && !rsp_ok) |-> $past(gnt_op) == OP_SC);

    // R6: a failing store-conditional leaves all reservations untouched.
    p_fail_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && gnt_op == OP_SC && !sc_pass) |=> resv_valid == $past(resv_valid));

    // R10: a passing store-conditional disarms its own reservation.
    p_sc_clears_own_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && gnt_op == OP_SC && sc_pass) |=> (resv_valid & $past(req_grant)) == '0);

endmodule

bind llsc_monitor llsc_monitor_chk #(
    .NUM_REQ (NUM_REQ)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_grant  (req_grant),
    .rsp_valid  (rsp_valid),
    .rsp_ok     (rsp_ok),
    .gnt_any    (gnt_any),
    .gnt_op     (gnt_op),
    .sc_pass    (sc_pass),
    .resv_valid (resv_valid)
);

// File: tb/tb_llsc_monitor.sv
// Bench for llsc_monitor: four requesters, 32 words, 4-word blocks.
module tb_llsc_monitor;

    localparam int N    = 4;
    localparam int AW   = 5;
    localparam int DW   = 16;
    localparam int BOFF = 2;
    localparam int WORDS = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req_valid = '0;
    logic [2*N-1:0]    req_op = '0;
    logic [AW*N-1:0]   req_addr = '0;
    logic [DW*N-1:0]   req_wdata = '0;
    logic [N-1:0]      req_grant;
    logic [N-1:0]      rsp_valid;
    logic              rsp_ok;
    logic [DW-1:0]     rsp_rdata;

    llsc_monitor #(
        .NUM_REQ   (N),
        .ADDR_W    (AW),
        .DATA_W    (DW),
        .BLK_OFF_W (BOFF)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_grant (req_grant),
        .rsp_valid (rsp_valid),
        .rsp_ok    (rsp_ok),
        .rsp_rdata (rsp_rdata)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int last_g = N - 1;
    logic [DW-1:0] seq = 16'h1000;

    // Reference state kept by the bench.
    logic [DW-1:0] m_mem [WORDS];
    logic          m_known [WORDS];
    logic          m_rv [N];
    int            m_rt [N];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected result of one operation, then update of the reference state.
    task automatic model(input int r, input int op, input int addr, input logic [DW-1:0] wd,
                         output bit ok, output bit known, output logic [DW-1:0] rd);
        int blk;
        bit wr;
        blk   = addr >> BOFF;
        ok    = (op == 3) ? (m_rv[r] && m_rt[r] == blk) : 1'b1;
        known = m_known[addr];
        rd    = m_mem[addr];
        if (op == 2) begin
            m_rv[r] = 1'b1;
            m_rt[r] = blk;
        end
        wr = (op == 1) || (op == 3 && ok);
        if (wr) begin
            m_mem[addr]   = wd;
            m_known[addr] = 1'b1;
            for (int i = 0; i < N; i++) begin
                if (i != r && m_rv[i] && m_rt[i] == blk) m_rv[i] = 1'b0;
            end
            if (op == 3) m_rv[r] = 1'b0;
        end
    endtask

    // Issue one operation from requester r and check the response.
    task automatic do_op(input int r, input int op, input int addr, input string tag);
        bit ok_e, known;
        logic [DW-1:0] rd_e;
        logic [DW-1:0] wd;
        int guard;
        seq = seq + 16'd1;
        wd  = seq;
        @(negedge clk);
        req_valid[r]         = 1'b1;
        req_op[2*r +: 2]     = 2'(op);
        req_addr[AW*r +: AW] = AW'(addr);
        req_wdata[DW*r +: DW] = wd;
        #1;
        guard = 0;
        while (!req_grant[r] && guard < 20) begin
            @(negedge clk);
            #1;
            guard++;
        end
        model(r, op, addr, wd, ok_e, known, rd_e);
        last_g = r;
        @(negedge clk);
        check(rsp_valid == N'(1 << r), {tag, " rsp_valid"}, rsp_valid, 1 << r);
        check(rsp_ok == ok_e, {tag, " rsp_ok"}, rsp_ok, ok_e);
        if (known) check(rsp_rdata == rd_e, {tag, " rsp_rdata"}, rsp_rdata, rd_e);
        req_valid[r] = 1'b0;
    endtask

    // Several requesters contend with plain loads; check rotation order (R2) and data (R3).
    task automatic rr_round(input logic [N-1:0] who);
        int exp_g, g;
        bit ok_e, known;
        logic [DW-1:0] rd_e;
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            if (who[i]) begin
                req_valid[i]         = 1'b1;
                req_op[2*i +: 2]     = 2'd0;
                req_addr[AW*i +: AW] = AW'(i * 3 + 1);
            end
        end
        #1;
        for (int n = 0; n < $countones(who); n++) begin
            exp_g = -1;
            for (int k = 1; k <= N; k++) begin
                if (exp_g < 0 && req_valid[(last_g + k) % N]) exp_g = (last_g + k) % N;
            end
            g = -1;
            for (int i = 0; i < N; i++) if (req_grant[i]) g = i;
            check(g == exp_g, "R2 round-robin order", g, exp_g);
            if (g < 0) g = exp_g;
            model(g, 0, g * 3 + 1, '0, ok_e, known, rd_e);
            last_g = g;
            @(negedge clk);
            check(rsp_valid == N'(1 << g), "R3 contended rsp_valid", rsp_valid, 1 << g);
            check(rsp_ok && rsp_rdata == rd_e, "R11 contended load data", rsp_rdata, rd_e);
            req_valid[g] = 1'b0;
            #1;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) m_known[i] = 1'b0;
        for (int i = 0; i < N; i++) begin
            m_rv[i] = 1'b0;
            m_rt[i] = 0;
        end

        // R1: requests during reset get no grant and no response.
        req_valid = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_grant == '0, "R1 no grant in reset", req_grant, 0);
        check(rsp_valid == '0, "R1 no response in reset", rsp_valid, 0);
        req_valid = '0;
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == '0, "R1 idle after reset", rsp_valid, 0);

        // R1: no reservation after reset, every store-conditional fails.
        for (int r = 0; r < N; r++) do_op(r, 3, r * 4, "R1 SC after reset");

        // Preload every word with plain stores (R7 store answers ok).
        for (int a = 0; a < WORDS; a++) do_op(a % N, 1, a, "R7 preload store");
        for (int a = 0; a < WORDS; a++) do_op((a + 1) % N, 0, a, "R11 load back");

        // R4/R5: plain LL then SC on the same word from each requester.
        for (int r = 0; r < N; r++) begin
            do_op(r, 2, r * 5, "R4 LL");
            do_op(r, 3, r * 5, "R5 SC same word");
        end

        // R10: second SC without new LL fails.
        do_op(1, 2, 9, "R4 LL");
        do_op(1, 3, 9, "R10 first SC");
        do_op(1, 3, 9, "R10 second SC");

        // R9: a new LL replaces the old reservation.
        do_op(2, 2, 0, "R9 LL block 0");
        do_op(2, 2, 8, "R9 LL block 2");
        do_op(2, 3, 1, "R9 SC old block");
        do_op(2, 3, 10, "R9 SC new block");

        // R11: owner's own plain store keeps its reservation.
        do_op(3, 2, 20, "R4 LL");
        do_op(3, 1, 21, "R11 own store");
        do_op(3, 3, 22, "R11 SC after own store");

        // Sweep: LL by a, interfering op by b at each word of the block and a neighbour,
        // then SC by a (R5 R6 R7 R8 R11).
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                for (int op = 0; op < 4; op++) begin
                    for (int w = 0; w < 5; w++) begin
                        int base, addr2;
                        base  = ((a + b + op) % 8) * 4;
                        addr2 = (w < 4) ? base + w : (base + 4) % WORDS;
                        do_op(a, 2, base + (w % 4), "R4 sweep LL");
                        do_op(b, op, addr2, "R8 sweep interferer");
                        do_op(a, 3, base + ((w + 1) % 4), "R6 R7 sweep SC");
                    end
                end
            end
        end

        // R6: failed SC from c leaves a and b reservations intact.
        do_op(0, 2, 12, "R4 LL");
        do_op(1, 2, 13, "R4 LL");
        do_op(2, 3, 14, "R6 failing SC");
        do_op(1, 3, 15, "R6 SC after foreign failure");
        do_op(0, 3, 12, "R7 SC after foreign commit");

        // R2: rotation with all and with sparse contenders.
        rr_round(4'b1111);
        rr_round(4'b1010);
        rr_round(4'b0101);
        rr_round(4'b1111);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule